// File: doc/BRIEF.md
# Serial Channel Framing and Baud Generator

This block holds the character-format and bit-rate settings for one channel of a serial controller. The host programs it through indexed 8-bit registers: an index, a data byte and a one-cycle write strobe. From these registers it decodes the framing that a UART shifter needs: parity on or off, even or odd parity, one or two stop bits, and a data length of 5 to 8 bits.

The same registers feed a programmable bit-rate generator. A 16-bit time constant `tc` divides the reference clock by `tc + 2`. A clock-mode field then divides the result again by 1, 16, 32 or 64, giving a one-cycle `baud_tick`. With the nominal 2 457 600 Hz reference, the bit rate is 2 457 600 / ((tc + 2) · mode divisor).

Top module: `serial_frame_baud`

## Requirements
- R1: After reset every register reads as zero. The outputs then show no parity, one stop bit, 5 data bits and 1x mode, and `baud_tick` repeats every 2 clock cycles.
- R2: Register index 4 bit 0 enables parity (`par_en`). While parity is enabled, bit 1 set gives even parity (`par_even` = 1) and bit 1 clear gives odd parity. `par_even` is 0 whenever parity is disabled.
- R3: `two_stop` is 1 only when bits 3:2 of register 4 are 11. The values 00, 01 and 10 all give one stop bit.
- R4: Bits 6:5 of register 5 set `data_bits`: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. The other bits of register 5 have no effect.
- R5: Writes to any index other than 4, 5, 12 and 13 change neither the framing outputs nor the tick period. The framing outputs change only in the cycle after a write.
- R6: Register 12 is the low byte of `tc` and register 13 is the high byte. In 1x mode, `baud_tick` pulses every `tc + 2` clock cycles.
- R7: Bits 7:6 of register 4 select the clock mode: 00 gives 1x, 01 gives 16x, 10 gives 32x and 11 gives 64x. The tick period is `(tc + 2)` times the mode divisor.
- R8: A change to the time constant does not cut short the period already running. That period completes at its old length, and the new length applies from the next reload.
- R9: `baud_tick` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | IDX_W | Write register index |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| two_stop | output | 1 | Two stop bits selected |
| data_bits | output | 4 | Character length, 5 to 8 |
| baud_tick | output | 1 | One-cycle bit-rate tick |

## Verification
The bench builds the block with the default 4-bit index, so every index from 0 to 15 can be written, including all the unused ones. Small time constants (0, 1, 3, 5, 10) keep even the 64x period down to a few hundred cycles, so every clock mode is timed tick to tick. A constant of 0x0100 exercises the high byte. The rewrite of the constant in the middle of a period tests the reload rule.

// File: rtl/serial_frame_baud.sv
module serial_frame_baud #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [7:0]       wr_data,
  input  logic             wr_en,
  output logic             par_en,
  output logic             par_even,
  output logic             two_stop,
  output logic [3:0]       data_bits,
  output logic             baud_tick
);
  localparam int TC_W  = 16;
  localparam int CNT_W = TC_W + 1;
  localparam logic [IDX_W-1:0] IDX_MODE = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_LEN  = IDX_W'(5);
  localparam logic [IDX_W-1:0] IDX_TCL  = IDX_W'(12);
  localparam logic [IDX_W-1:0] IDX_TCH  = IDX_W'(13);

  logic [7:0] mode_r, len_r, tcl_r, tch_r;
  logic [CNT_W-1:0] div_cnt, reload;
  logic [5:0] pre_cnt, pre_reload;
  logic gen_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      len_r  <= '0;
      tcl_r  <= '0;
      tch_r  <= '0;
    end else if (wr_en) begin
      if (reg_idx == IDX_MODE) mode_r <= wr_data;
      if (reg_idx == IDX_LEN)  len_r  <= wr_data;
      if (reg_idx == IDX_TCL)  tcl_r  <= wr_data;
      if (reg_idx == IDX_TCH)  tch_r  <= wr_data;
    end
  end

  assign par_en   = mode_r[0];
  assign par_even = mode_r[0] & mode_r[1];
  assign two_stop = (mode_r[3:2] == 2'b11);

  always_comb begin
    case (len_r[6:5])
      2'b00:   data_bits = 4'd5;
      2'b01:   data_bits = 4'd7;
      2'b10:   data_bits = 4'd6;
      default: data_bits = 4'd8;
    endcase
  end

  always_comb begin
    case (mode_r[7:6])
      2'b00:   pre_reload = 6'd0;
      2'b01:   pre_reload = 6'd15;
      2'b10:   pre_reload = 6'd31;
      default: pre_reload = 6'd63;
    endcase
  end

  assign reload    = {1'b0, tch_r, tcl_r} + CNT_W'(1);
  assign gen_pulse = (div_cnt == '0);
  assign baud_tick = gen_pulse && (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      pre_cnt <= '0;
    end else begin
      div_cnt <= gen_pulse ? reload : div_cnt - CNT_W'(1);
      if (gen_pulse)
        pre_cnt <= (pre_cnt == '0) ? pre_reload : pre_cnt - 6'd1;
    end
  end
endmodule

// File: rtl/serial_frame_baud_chk.sv
module serial_frame_baud_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CNT_W-1:0] cnt,
  input logic             par_en,
  input logic             par_even,
  input logic             two_stop,
  input logic [3:0]       data_bits,
  input logic             baud_tick
);
  assert_even_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_even |-> par_en);

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_bits >= 4'd5 && data_bits <= 4'd8);

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({par_en, par_even, two_stop, data_bits}));

  assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1));

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

bind serial_frame_baud serial_frame_baud_chk #(.CNT_W(17)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt(div_cnt),
  .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
  .data_bits(data_bits), .baud_tick(baud_tick)
);

// File: tb/serial_frame_baud_tb.sv
module serial_frame_baud_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] wr_data = '0;
  logic wr_en = 1'b0;
  logic par_en, par_even, two_stop, baud_tick;
  logic [3:0] data_bits;

  int checks = 0;
  int errors = 0;
  int since = 0;
  int b2b = 0;
  logic prev_tick = 1'b0;

  logic [6:0] cfg_q[$];
  string      cfg_tag[$];
  int         per_q[$];
  string      per_tag[$];

  always #5 clk = ~clk;

  serial_frame_baud u_dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_data(wr_data), .wr_en(wr_en),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .data_bits(data_bits), .baud_tick(baud_tick)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = cfg_q.pop_front();
        t = cfg_tag.pop_front();
        checks++;
        if ({par_en, par_even, two_stop, data_bits} !== e) begin
          errors++;
          $display("FAIL %s: cfg actual %b expected %b", t,
                   {par_en, par_even, two_stop, data_bits}, e);
        end
      end
      since++;
      if (baud_tick && prev_tick) b2b++;
      prev_tick = baud_tick;
      if (baud_tick) begin
        if (per_q.size() > 0) begin
          int e;
          string t;
          e = per_q.pop_front();
          t = per_tag.pop_front();
          checks++;
          if (since != e) begin
            errors++;
            $display("FAIL %s: tick period actual %0d expected %0d", t, since, e);
          end
        end
        since = 0;
      end
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    reg_idx = 4'(idx);
    wr_data = 8'(val);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_cfg(input bit pe, input bit ev, input bit ts, input int nb, input string tag);
    #1;
    cfg_q.push_back({pe, ev, ts, 4'(nb)});
    cfg_tag.push_back(tag);
    while (cfg_q.size() > 0) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!baud_tick);
    @(posedge clk);
  endtask

  task automatic exp_per(input int p, input int n, input string tag);
    wait_tick();
    for (int i = 0; i < n; i++) begin
      per_q.push_back(p);
      per_tag.push_back(tag);
    end
    while (per_q.size() > 0) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cfg(0, 0, 0, 5, "R1 reset framing");
    exp_per(2, 2, "R1 reset period");

    wr(4, 8'h01); exp_cfg(1, 0, 0, 5, "R2 odd parity");
    wr(4, 8'h03); exp_cfg(1, 1, 0, 5, "R2 even parity");
    wr(4, 8'h02); exp_cfg(0, 0, 0, 5, "R2 parity off");

    wr(4, 8'h0C); exp_cfg(0, 0, 1, 5, "R3 two stop");
    wr(4, 8'h04); exp_cfg(0, 0, 0, 5, "R3 stop 01");
    wr(4, 8'h08); exp_cfg(0, 0, 0, 5, "R3 stop 10");
    wr(4, 8'h0D); exp_cfg(1, 0, 1, 5, "R3 two stop odd");

    wr(5, 8'h20); exp_cfg(1, 0, 1, 7, "R4 len 01");
    wr(5, 8'h40); exp_cfg(1, 0, 1, 6, "R4 len 10");
    wr(5, 8'h60); exp_cfg(1, 0, 1, 8, "R4 len 11");
    wr(5, 8'h9F); exp_cfg(1, 0, 1, 5, "R4 len 00 other bits");

    wr(4, 8'h03); wr(5, 8'h60);
    exp_cfg(1, 1, 0, 8, "R5 setup");
    wr(0, 8'hFF); wr(3, 8'hFF); wr(6, 8'hFF);
    wr(11, 8'hFF); wr(14, 8'hFF); wr(15, 8'hFF);
    exp_cfg(1, 1, 0, 8, "R5 ignored indices framing");
    exp_per(2, 2, "R5 ignored indices period");

    wr(12, 5);
    exp_per(7, 2, "R6 tc 5");
    wr(12, 0); wr(13, 1);
    exp_per(258, 2, "R6 tc 0x0100");
    wr(13, 0);
    exp_per(2, 2, "R6 tc 0");

    wr(12, 1);
    wr(4, 8'h40); exp_per(48, 2, "R7 16x");
    wr(4, 8'h80); exp_per(96, 2, "R7 32x");
    wr(4, 8'hC0); exp_per(192, 2, "R7 64x");
    wr(12, 3);    exp_per(320, 1, "R7 64x tc 3");

    wr(4, 8'h00); wr(12, 10);
    exp_per(12, 1, "R8 setup");
    wait_tick();
    per_q.push_back(12); per_tag.push_back("R8 old period kept");
    per_q.push_back(4);  per_tag.push_back("R8 new period");
    per_q.push_back(4);  per_tag.push_back("R8 new period");
    repeat (3) @(negedge clk);
    wr(12, 2);
    while (per_q.size() > 0) @(negedge clk);

    checks++;
    if (b2b != 0) begin
      errors++;
      $display("FAIL R9: back-to-back ticks actual %0d expected 0", b2b);
    end

    report();
    $finish;
  end
endmodule